// File: doc/BRIEF.md
# Sleep and Wake Control Unit

This block sits next to a small processor core and owns the decision of when the core sleeps and when it wakes. The core raises one of two sleep requests. The first waits for an interrupt. The second waits for an event. The unit watches a vector of pending interrupts, with an enable bit and a priority field for each one, and compares them against the core's current execution priority. It also watches a global interrupt mask, an external event line, an event pulse from a peer core, and an option that lets any freshly pending interrupt count as an event.

A one-bit sticky event latch remembers an event that arrived while the core was not waiting for one. A later wait-for-event request consumes the latch and falls straight through without sleeping. Waking and servicing are separate outputs. When the global mask is set, a qualifying interrupt still wakes the core, but the handler qualifier stays low until the mask is cleared. If the deep-sleep select is high when a sleep request is accepted, the unit enters deep sleep instead. A wake from deep sleep then passes through a restore phase of a parameterised length, during which a wake request to the power controller is held high and no handler may be taken.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: With the unit awake and `deep_sel` low, `req_wait_irq` puts the unit into interrupt-wait sleep at the next edge, so `sleeping` reads 1. If both requests are high in the same cycle, `req_wait_irq` wins.
- R2: A qualifying interrupt is one whose pending and enable bits are both 1 and whose priority field is numerically below `cur_prio`. A lower value means higher priority, and an equal value does not qualify. Interrupt-wait sleep ends only on a qualifying interrupt. Events have no effect on it.
- R3: `take_ok` is 1 exactly when the unit is awake, a qualifying interrupt exists, and `mask_all` is 0. A qualifying interrupt with `mask_all` at 1 still wakes the core, and `take_ok` then rises in the cycle `mask_all` returns to 0.
- R4: Event-wait sleep ends on a qualifying interrupt, on `ext_evt` high, or on `peer_evt` high. An `ext_evt` tied low never wakes the unit.
- R5: With `pend_is_event` at 1, a 0-to-1 change of any pending bit counts as an event. This holds even when that interrupt is disabled or its priority is too low. A bit that stays pending produces no further events.
- R6: An event that is not consumed sets the event latch, and reset clears the latch. A `req_wait_evt` arriving while the latch is set, or together with an event, leaves the unit awake and clears the latch. Waking from event-wait sleep also clears the latch.
- R7: When a sleep request is accepted while `deep_sel` is 1, the unit enters deep sleep and `deep_sleeping` reads 1. Later changes of `deep_sel` have no effect. The wake conditions in deep sleep are those of the request that entered it.
- R8: A wake from deep sleep is followed by exactly RESTORE_CYCLES cycles with `pmu_wake_req` at 1 and `take_ok` at 0. The unit is awake after that.
- R9: `wake_pulse` is 1 for exactly one cycle: the first cycle after the unit leaves any sleep state.
- R10: During and right after reset the unit is awake, and `sleeping`, `deep_sleeping`, `wake_pulse`, `take_ok` and `pmu_wake_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_wait_irq | input | 1 | Core asks to sleep until an interrupt |
| req_wait_evt | input | 1 | Core asks to sleep until an event |
| irq_pend | input | NUM_IRQ | Pending bit of each interrupt |
| irq_en | input | NUM_IRQ | Enable bit of each interrupt |
| irq_prio | input | NUM_IRQ*PRIO_W | Priority field of each interrupt; interrupt i occupies bits i*PRIO_W upward |
| cur_prio | input | PRIO_W | Current execution priority |
| mask_all | input | 1 | Global mask; blocks handler entry but not wakeup |
| ext_evt | input | 1 | External event line, active high |
| peer_evt | input | 1 | Event pulse from a peer core |
| pend_is_event | input | 1 | Newly pending interrupts count as events |
| deep_sel | input | 1 | Select deep sleep at sleep entry |
| sleeping | output | 1 | Unit is in any sleep state |
| deep_sleeping | output | 1 | Unit is in deep sleep |
| wake_pulse | output | 1 | One-cycle pulse after leaving sleep |
| take_ok | output | 1 | An interrupt handler may be entered now |
| pmu_wake_req | output | 1 | Wake request to the power controller, held during restore |

## Verification
Directed patterns separate each wake rule. An interrupt at the same priority as the current level, then one a step higher, tells the strict comparison apart from a non-strict one. An event sent to an interrupt-wait sleep checks that events are ignored there, while the same event sent to an event-wait sleep must wake it. A disabled interrupt becoming pending, then staying pending, separates edge detection from level detection. Events before a wait request exercise the latch fall-through. Dropping `deep_sel` during deep sleep and counting the restore cycles pin down R7 and R8. A long seeded random mix of requests, events, mask changes and pending flips is then compared cycle by cycle against a reference model in the bench.

// File: rtl/swc_pkg.sv
package swc_pkg;
  typedef enum logic [2:0] {
    ST_AWAKE   = 3'd0,
    ST_NAP_IRQ = 3'd1,
    ST_NAP_EVT = 3'd2,
    ST_DEEP    = 3'd3,
    ST_RESTORE = 3'd4
  } swc_state_e;
endpackage

// File: rtl/swc_irq_eval.sv
module swc_irq_eval #(
  parameter int NUM_IRQ = 8,
  parameter int PRIO_W  = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_IRQ-1:0]        irq_pend,
  input  logic [NUM_IRQ-1:0]        irq_en,
  input  logic [NUM_IRQ*PRIO_W-1:0] irq_prio,
  input  logic [PRIO_W-1:0]         cur_prio,
  output logic                      irq_qual,
  output logic                      pend_edge
);
  logic [NUM_IRQ-1:0] pend_q;
  logic [NUM_IRQ-1:0] qual_vec;

  // Lower numeric value means higher priority; strictly below current level.
  for (genvar gi = 0; gi < NUM_IRQ; gi++) begin : g_qual
    assign qual_vec[gi] = irq_pend[gi] & irq_en[gi] &
                          (irq_prio[gi*PRIO_W +: PRIO_W] < cur_prio);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= irq_pend;
  end

  assign irq_qual  = |qual_vec;
  assign pend_edge = |(irq_pend & ~pend_q);
endmodule

// File: rtl/swc_event_latch.sv
module swc_event_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic latch_o
);
  logic latch_q, latch_d, latch_en;

  assign latch_en = set_i | clr_i;
  assign latch_d  = clr_i ? 1'b0 : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        latch_q <= 1'b0;
    else if (latch_en) latch_q <= latch_d;
  end

  assign latch_o = latch_q;

  AST_LATCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !latch_o) else $error("latch not cleared"); // R6
  AST_LATCH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !clr_i) |=> latch_o) else $error("latch not set"); // R6
endmodule

// File: rtl/swc_restore_timer.sv
module swc_restore_timer #(
  parameter int CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = start_i | (run_i & (cnt_q != '0));

  always_comb begin
    if (start_i) cnt_d = CW'(CYCLES - 1);
    else         cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done_o = (cnt_q == '0);

  AST_TIMER_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !start_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1))
    else $error("restore timer stalled"); // R8
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
  import swc_pkg::*;
#(
  parameter int NUM_IRQ        = 8,
  parameter int PRIO_W         = 2,
  parameter int RESTORE_CYCLES = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_wait_irq,
  input  logic                      req_wait_evt,
  input  logic [NUM_IRQ-1:0]        irq_pend,
  input  logic [NUM_IRQ-1:0]        irq_en,
  input  logic [NUM_IRQ*PRIO_W-1:0] irq_prio,
  input  logic [PRIO_W-1:0]         cur_prio,
  input  logic                      mask_all,
  input  logic                      ext_evt,
  input  logic                      peer_evt,
  input  logic                      pend_is_event,
  input  logic                      deep_sel,
  output logic                      sleeping,
  output logic                      deep_sleeping,
  output logic                      wake_pulse,
  output logic                      take_ok,
  output logic                      pmu_wake_req
);
  swc_state_e state_q, state_d;
  logic       dp_evt_q, dp_evt_d;
  logic       wake_q, wake_d;
  logic       irq_qual, pend_edge, event_in;
  logic       latch, consume, tmr_start, tmr_done;

  swc_irq_eval #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_eval (
    .clk(clk), .rst_n(rst_n), .irq_pend(irq_pend), .irq_en(irq_en),
    .irq_prio(irq_prio), .cur_prio(cur_prio),
    .irq_qual(irq_qual), .pend_edge(pend_edge)
  );

  assign event_in = ext_evt | peer_evt | (pend_is_event & pend_edge);

  swc_event_latch u_latch (
    .clk(clk), .rst_n(rst_n), .set_i(event_in), .clr_i(consume), .latch_o(latch)
  );

  swc_restore_timer #(.CYCLES(RESTORE_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start_i(tmr_start),
    .run_i(state_q == ST_RESTORE), .done_o(tmr_done)
  );

  // Next-state logic
  always_comb begin
    state_d   = state_q;
    dp_evt_d  = dp_evt_q;
    wake_d    = 1'b0;
    consume   = 1'b0;
    tmr_start = 1'b0;
    unique case (state_q)
      ST_AWAKE: begin
        if (req_wait_irq) begin
          dp_evt_d = 1'b0;
          state_d  = deep_sel ? ST_DEEP : ST_NAP_IRQ;
        end else if (req_wait_evt) begin
          if (latch | event_in) begin
            consume = 1'b1;
          end else begin
            dp_evt_d = 1'b1;
            state_d  = deep_sel ? ST_DEEP : ST_NAP_EVT;
          end
        end
      end
      ST_NAP_IRQ: begin
        if (irq_qual) begin
          state_d = ST_AWAKE;
          wake_d  = 1'b1;
        end
      end
      ST_NAP_EVT: begin
        if (irq_qual | event_in) begin
          state_d = ST_AWAKE;
          wake_d  = 1'b1;
          consume = 1'b1;
        end
      end
      ST_DEEP: begin
        if (irq_qual | (dp_evt_q & event_in)) begin
          state_d   = ST_RESTORE;
          wake_d    = 1'b1;
          tmr_start = 1'b1;
          consume   = dp_evt_q;
        end
      end
      ST_RESTORE: begin
        if (tmr_done) state_d = ST_AWAKE;
      end
      default: state_d = ST_AWAKE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_AWAKE;
      dp_evt_q <= 1'b0;
      wake_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      dp_evt_q <= dp_evt_d;
      wake_q   <= wake_d;
    end
  end

  assign sleeping      = (state_q == ST_NAP_IRQ) | (state_q == ST_NAP_EVT) |
                         (state_q == ST_DEEP);
  assign deep_sleeping = (state_q == ST_DEEP);
  assign wake_pulse    = wake_q;
  assign pmu_wake_req  = (state_q == ST_RESTORE);
  assign take_ok       = (state_q == ST_AWAKE) & irq_qual & ~mask_all;

  AST_IRQ_NAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_NAP_IRQ && !irq_qual) |=> sleeping)
    else $error("interrupt-wait left without cause"); // R2
  AST_DEEP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DEEP && !irq_qual && !(dp_evt_q && event_in)) |=> deep_sleeping)
    else $error("deep sleep left without cause"); // R7
  AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse) else $error("wake pulse too long"); // R9
  AST_WAKE_AFTER_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> $past(sleeping)) else $error("wake pulse without sleep"); // R9
  AST_RESTORE_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    pmu_wake_req |-> !take_ok) else $error("handler during restore"); // R8
endmodule

// File: tb/tb_sleep_wake_ctrl.sv
module tb_sleep_wake_ctrl;
  localparam int N  = 8;
  localparam int PW = 2;
  localparam int RC = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, req_wait_irq, req_wait_evt, mask_all, ext_evt, peer_evt;
  logic pend_is_event, deep_sel;
  logic [N-1:0] irq_pend, irq_en;
  logic [N*PW-1:0] irq_prio;
  logic [PW-1:0] cur_prio;
  logic sleeping, deep_sleeping, wake_pulse, take_ok, pmu_wake_req;

  sleep_wake_ctrl #(.NUM_IRQ(N), .PRIO_W(PW), .RESTORE_CYCLES(RC)) dut (
    .clk(clk), .rst_n(rst_n), .req_wait_irq(req_wait_irq), .req_wait_evt(req_wait_evt),
    .irq_pend(irq_pend), .irq_en(irq_en), .irq_prio(irq_prio), .cur_prio(cur_prio),
    .mask_all(mask_all), .ext_evt(ext_evt), .peer_evt(peer_evt),
    .pend_is_event(pend_is_event), .deep_sel(deep_sel),
    .sleeping(sleeping), .deep_sleeping(deep_sleeping), .wake_pulse(wake_pulse),
    .take_ok(take_ok), .pmu_wake_req(pmu_wake_req)
  );

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  // Reference model: 0 awake, 1 irq-wait, 2 event-wait, 3 deep, 4 restore
  int m_st, m_cnt;
  bit m_latch, m_wake, m_dpe;
  logic [N-1:0] m_pq;

  function automatic bit f_qual();
    for (int i = 0; i < N; i++)
      if (irq_pend[i] && irq_en[i] && (irq_prio[i*PW +: PW] < cur_prio)) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [4:0] f_expect(bit q);
    if (!rst_n) return 5'b0;
    return {m_st inside {1, 2, 3}, m_st == 3, m_wake, m_st == 4,
            (m_st == 0) && q && !mask_all};
  endfunction

  task automatic chk(string tag, logic [4:0] act, logic [4:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {sleep,deep,wake,pmu,take} actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic tick(string tag);
    bit q, ev, consume;
    int nst;
    bit nwake;
    #1;
    q  = f_qual();
    ev = ext_evt || peer_evt || (pend_is_event && |(irq_pend & ~m_pq));
    chk(tag, {sleeping, deep_sleeping, wake_pulse, pmu_wake_req, take_ok}, f_expect(q));
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_latch = 0; m_wake = 0; m_dpe = 0; m_pq = '0;
    end else begin
      nst = m_st; nwake = 0; consume = 0;
      case (m_st)
        0: if (req_wait_irq) begin m_dpe = 0; nst = deep_sel ? 3 : 1; end
           else if (req_wait_evt) begin
             if (m_latch || ev) consume = 1;
             else begin m_dpe = 1; nst = deep_sel ? 3 : 2; end
           end
        1: if (q) begin nst = 0; nwake = 1; end
        2: if (q || ev) begin nst = 0; nwake = 1; consume = 1; end
        3: if (q || (m_dpe && ev)) begin nst = 4; nwake = 1; m_cnt = RC; consume = m_dpe; end
        default: if (m_cnt <= 1) nst = 0; else m_cnt--;
      endcase
      m_latch = consume ? 1'b0 : (m_latch | ev);
      m_st = nst; m_wake = nwake; m_pq = irq_pend;
    end
    @(negedge clk);
  endtask

  task automatic quiet();
    req_wait_irq = 0; req_wait_evt = 0; ext_evt = 0; peer_evt = 0;
  endtask

  task automatic clear_irqs();
    irq_pend = '0; irq_en = '0; irq_prio = '0; cur_prio = 2'd2; mask_all = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    rst_n = 0; quiet(); clear_irqs(); pend_is_event = 0; deep_sel = 0;
    m_st = 0; m_cnt = 0; m_latch = 0; m_wake = 0; m_dpe = 0; m_pq = '0;
    @(negedge clk);
    tick("R10 in reset"); tick("R10 in reset");
    rst_n = 1;
    tick("R10 after reset");

    // R2: equal priority does not wake; higher does; events ignored
    req_wait_irq = 1; req_wait_evt = 1; tick("R1 entry, irq request wins");
    quiet();
    irq_pend[0] = 1; irq_en[0] = 1; irq_prio[1:0] = 2'd2;
    tick("R2 equal priority"); tick("R2 equal priority");
    ext_evt = 1; peer_evt = 1; tick("R2 events ignored"); quiet();
    irq_prio[1:0] = 2'd1; tick("R2 higher priority wakes");
    tick("R9 wake pulse");
    tick("R9 pulse ends");
    clear_irqs(); tick("R6 drain");

    // R3: masked wake, then handler once mask clears
    mask_all = 1; req_wait_irq = 1; tick("R3 entry"); quiet();
    irq_pend[3] = 1; irq_en[3] = 1; irq_prio[7:6] = 2'd0;
    tick("R3 masked wake"); tick("R3 take held low"); tick("R3 take held low");
    mask_all = 0; tick("R3 take after unmask");
    clear_irqs(); tick("R3 idle");

    // R4: event-wait wakes on external and peer events
    req_wait_evt = 1; tick("R4 entry"); quiet(); tick("R4 asleep");
    ext_evt = 1; tick("R4 ext wake"); quiet(); tick("R4 awake");
    req_wait_evt = 1; tick("R4 entry"); quiet();
    peer_evt = 1; tick("R4 peer wake"); quiet(); tick("R4 awake");

    // R5: disabled, new pending wakes event-wait; held pending does not
    pend_is_event = 1; irq_pend[5] = 1; tick("R5 latch from edge");
    req_wait_evt = 1; tick("R6 latch fall-through"); quiet();
    req_wait_evt = 1; tick("R5 entry, level no event"); quiet();
    tick("R5 held pend"); tick("R5 held pend");
    irq_pend[6] = 1; tick("R5 new edge wakes");
    tick("R5 awake"); pend_is_event = 0; clear_irqs(); tick("R5 idle");

    // R6: event while awake then wait
    ext_evt = 1; tick("R6 set latch"); quiet(); tick("R6 latch held");
    req_wait_evt = 1; tick("R6 consume"); quiet(); tick("R6 still awake");
    req_wait_evt = 1; tick("R6 sleeps after consume"); quiet(); tick("R6 asleep");
    peer_evt = 1; tick("R6 wake"); quiet(); tick("R6 idle");

    // R7/R8: deep sleep with deep_sel dropped
    deep_sel = 1; req_wait_irq = 1; tick("R7 deep entry"); quiet(); deep_sel = 0;
    tick("R7 deep held"); ext_evt = 1; tick("R7 event ignored"); quiet(); tick("R7 deep held");
    irq_pend[1] = 1; irq_en[1] = 1; irq_prio[3:2] = 2'd0;
    tick("R7 deep wake");
    for (int k = 0; k < RC + 2; k++) tick("R8 restore window");
    clear_irqs();
    deep_sel = 1; req_wait_evt = 1; tick("R7 deep event entry"); quiet(); deep_sel = 0;
    tick("R7 deep held"); peer_evt = 1; tick("R7 deep event wake"); quiet();
    for (int k = 0; k < RC + 2; k++) tick("R8 restore window");

    // Random mix
    for (int c = 0; c < 4000; c++) begin
      req_wait_irq  = ($urandom % 10) == 0;
      req_wait_evt  = ($urandom % 8) == 0;
      ext_evt       = ($urandom % 20) == 0;
      peer_evt      = ($urandom % 25) == 0;
      mask_all      = ($urandom % 4) == 0;
      deep_sel      = ($urandom % 4) == 0;
      pend_is_event = ($urandom % 2) == 0;
      for (int i = 0; i < N; i++) if (($urandom % 40) == 0) irq_pend[i] = ~irq_pend[i];
      if (($urandom % 30) == 0) irq_en = N'($urandom);
      if (($urandom % 30) == 0) irq_prio = (N*PW)'($urandom);
      if (($urandom % 30) == 0) cur_prio = PW'($urandom);
      tick("random mix R1 R2 R3 R4 R5 R6 R7 R8 R9");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule